// File: doc/BRIEF.md
# Clear-on-Read Network Statistics Counter Bank

This block keeps a set of network event counters that software reads through a small byte-addressed window. The transmit and receive paths send it single-cycle pulses for line events (lost carrier, missing heartbeat, collisions of several kinds, receive overruns, frames sent and received, deferrals). They also send per-cycle byte increments for the two traffic-volume counters. Software must issue a one-cycle enable command before any counting starts.

A counter is cleared by the act of reading it. Software adds each value it reads into its own wide totals. Counting is never paused for a read: an event that lands in the same cycle as the read of its counter is carried into the next counting period. The transmitted-frame count is ten bits wide. Its low byte has its own offset, and its top two bits sit in a shared extension byte, so each part clears only when its own offset is read. A single status output goes high when any counter reaches its top bit, which tells software to empty the bank before a counter wraps.

Top module: `stats_counter_bank`

## Requirements
- R1: After reset every counter is zero, statsFull is low and rdValid is low.
- R2: Event pulses and byte increments have no effect until a one-cycle statsEnable pulse is seen. Counting starts in the cycle after that pulse and stays on until reset.
- R3: evtPulse bit i adds one to the 8-bit counter at byte offset i. The bits are: 0 carrier lost, 1 heartbeat missing, 2 multiple collisions, 3 single collisions, 4 late collisions, 5 receive overruns, 6 transmitted frames (low byte), 7 received frames, 8 deferrals.
- R4: A read (rdEn high, offset on rdAddr) returns the counter value held before that read on rdData, with rdValid high, one cycle later. Reads of offsets 0 to 9 return the value in rdData[7:0], with rdData[15:8] zero.
- R5: A read sets the addressed counter to zero and leaves every other counter unchanged.
- R6: When an event or increment for a counter arrives in the same cycle as a read of that counter, the counter restarts from that event's contribution (1 for a pulse) instead of from 0.
- R7: The transmitted-frame counter is 10 bits wide. Offset 9 returns its bits 9:8 in rdData[5:4], with every other bit of offset 9 zero. A carry out of the low byte increments those two bits.
- R8: A read of offset 9 clears only the transmitted-frame bits 9:8. A read of offset 6 clears only bits 7:0.
- R9: Offsets 10 and 12 are 16-bit counters of received and transmitted bytes. Each cycle they add rxByteInc and txByteInc (0 to 7), and they wrap modulo 65536.
- R10: statsFull is high exactly when some counter has its top bit set: bit 7 of an 8-bit counter other than transmitted frames, bit 9 of the transmitted-frame counter, or bit 15 of a byte counter. It falls once all such counters have been read.
- R11: Reads of offsets 11, 13, 14 and 15 return zero and clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| statsEnable | input | 1 | One-cycle command that turns counting on |
| evtPulse | input | 9 | Event pulses, bit i counts into offset i |
| rxByteInc | input | 3 | Received bytes to add this cycle |
| txByteInc | input | 3 | Transmitted bytes to add this cycle |
| rdEn | input | 1 | Read strobe; clears the addressed counter |
| rdAddr | input | 4 | Byte offset of the read |
| rdData | output | 16 | Read result, valid with rdValid |
| rdValid | output | 1 | High one cycle after rdEn |
| statsFull | output | 1 | Some counter has reached its top bit |

## Verification
One property checks that statsFull falls only in the cycle after a read. That holds only if software empties each counter before it wraps from its top-bit region back to zero, so the stimulus reads the bank often enough that no counter gets more than a few hundred events past the last read of it. The other properties rely only on rdEn and rdAddr being known every cycle out of reset. The bench drives every input from its own tasks, so they never carry unknown values. The random phase reads the offsets in rotation every other cycle, which keeps every counter far from its wrap point.

// File: rtl/stats_bank_pkg.sv
package stats_bank_pkg;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 16;
  localparam int NUM_BYTE   = 9;
  localparam int OFS_TXFRM  = 6;
  localparam int OFS_EXT    = 9;
  localparam int OFS_RXBYTE = 10;
  localparam int OFS_TXBYTE = 12;
  localparam int EXT_LSB    = 4;
  localparam int NUM_WIDE   = 2;

  typedef struct packed {
    logic                countEn;
    logic [NUM_BYTE-1:0] clrByte;
    logic                clrExt;
    logic [NUM_WIDE-1:0] clrWide;
  } statsStrobes_t;
endpackage

// File: rtl/stats_ctrl.sv
module stats_ctrl
  import stats_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              statsEnable,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] muxData,
  output statsStrobes_t     strobes,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int WIDE_OFS [NUM_WIDE] = '{OFS_RXBYTE, OFS_TXBYTE};

  logic countEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countEnQ <= 1'b0;
    end else if (statsEnable) begin
      countEnQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= muxData;
    end
  end

  always_comb strobes.countEn = countEnQ;

  for (genvar i = 0; i < NUM_BYTE; i++) begin : g_clrByte
    assign strobes.clrByte[i] = rdEn && (rdAddr == ADDR_W'(i));
  end

  for (genvar k = 0; k < NUM_WIDE; k++) begin : g_clrWide
    assign strobes.clrWide[k] = rdEn && (rdAddr == ADDR_W'(WIDE_OFS[k]));
  end

  assign strobes.clrExt = rdEn && (rdAddr == ADDR_W'(OFS_EXT));
endmodule

// File: rtl/stats_datapath.sv
module stats_datapath
  import stats_bank_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int EXT_W  = 2,
  parameter int WIDE_W = 16,
  parameter int INC_W  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  statsStrobes_t       strobes,
  input  logic [NUM_BYTE-1:0] evtPulse,
  input  logic [INC_W-1:0]    rxByteInc,
  input  logic [INC_W-1:0]    txByteInc,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   muxData,
  output logic                statsFull
);
  logic [CNT_W-1:0]    byteCnt  [NUM_BYTE];
  logic [NUM_BYTE-1:0] carry;
  logic [NUM_BYTE-1:0] byteTop;
  logic [EXT_W-1:0]    extCnt;
  logic [WIDE_W-1:0]   wideCnt  [NUM_WIDE];
  logic [INC_W-1:0]    wideInc  [NUM_WIDE];
  logic [NUM_WIDE-1:0] wideTop;

  assign wideInc[0] = rxByteInc;
  assign wideInc[1] = txByteInc;

  for (genvar i = 0; i < NUM_BYTE; i++) begin : g_byte
    logic [CNT_W:0] sum;
    always_comb begin
      sum = {1'b0, (strobes.clrByte[i] ? '0 : byteCnt[i])}
          + (CNT_W + 1)'(strobes.countEn & evtPulse[i]);
    end
    always_ff @(posedge clk) begin
      if (!rstN) byteCnt[i] <= '0;
      else       byteCnt[i] <= sum[CNT_W-1:0];
    end
    assign carry[i] = sum[CNT_W];
    if (i == OFS_TXFRM) begin : g_ext
      assign byteTop[i] = 1'b0;
    end else begin : g_plain
      assign byteTop[i] = byteCnt[i][CNT_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) extCnt <= '0;
    else extCnt <= (strobes.clrExt ? '0 : extCnt) + EXT_W'(carry[OFS_TXFRM]);
  end

  for (genvar k = 0; k < NUM_WIDE; k++) begin : g_wide
    logic [WIDE_W-1:0] addVal;
    assign addVal = strobes.countEn ? WIDE_W'(wideInc[k]) : '0;
    always_ff @(posedge clk) begin
      if (!rstN) wideCnt[k] <= '0;
      else       wideCnt[k] <= (strobes.clrWide[k] ? '0 : wideCnt[k]) + addVal;
    end
    assign wideTop[k] = wideCnt[k][WIDE_W-1];
  end

  always_comb begin
    muxData = '0;
    if (rdAddr < ADDR_W'(NUM_BYTE)) begin
      for (int i = 0; i < NUM_BYTE; i++) begin
        if (rdAddr == ADDR_W'(i)) muxData = DATA_W'(byteCnt[i]);
      end
    end else if (rdAddr == ADDR_W'(OFS_EXT)) begin
      muxData[EXT_LSB +: EXT_W] = extCnt;
    end else if (rdAddr == ADDR_W'(OFS_RXBYTE)) begin
      muxData = DATA_W'(wideCnt[0]);
    end else if (rdAddr == ADDR_W'(OFS_TXBYTE)) begin
      muxData = DATA_W'(wideCnt[1]);
    end
  end

  assign statsFull = (|byteTop) | extCnt[EXT_W-1] | (|wideTop);
endmodule

// File: rtl/stats_counter_bank.sv
module stats_counter_bank
  import stats_bank_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int EXT_W  = 2,
  parameter int WIDE_W = 16,
  parameter int INC_W  = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          statsEnable,
  input  logic [8:0]    evtPulse,
  input  logic [2:0]    rxByteInc,
  input  logic [2:0]    txByteInc,
  input  logic          rdEn,
  input  logic [3:0]    rdAddr,
  output logic [15:0]   rdData,
  output logic          rdValid,
  output logic          statsFull
);
  statsStrobes_t     strobes;
  logic [DATA_W-1:0] muxData;

  stats_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .statsEnable (statsEnable),
    .rdEn        (rdEn),
    .rdAddr      (rdAddr),
    .muxData     (muxData),
    .strobes     (strobes),
    .rdData      (rdData),
    .rdValid     (rdValid)
  );

  stats_datapath #(
    .CNT_W  (CNT_W),
    .EXT_W  (EXT_W),
    .WIDE_W (WIDE_W),
    .INC_W  (INC_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .evtPulse  (evtPulse),
    .rxByteInc (rxByteInc),
    .txByteInc (txByteInc),
    .rdAddr    (rdAddr),
    .muxData   (muxData),
    .statsFull (statsFull)
  );
endmodule

// File: rtl/stats_counter_bank_checker.sv
module stats_counter_bank_checker (
  input logic        clk,
  input logic        rstN,
  input logic        statsEnable,
  input logic        rdEn,
  input logic [3:0]  rdAddr,
  input logic [15:0] rdData,
  input logic        rdValid,
  input logic        statsFull
);
  logic seenEnable;

  always_ff @(posedge clk) begin
    if (!rstN) seenEnable <= 1'b0;
    else if (statsEnable) seenEnable <= 1'b1;
  end

  // R4: result appears exactly one cycle after the strobe
  assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);
  assert_no_stray_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);
  assert_byte_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr <= 4'd9) |=> (rdData[15:8] == 8'h00));
  assert_ext_spare_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == 4'd9) |=> (rdData[7:6] == 2'b00 && rdData[3:0] == 4'h0));
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (rdAddr == 4'd11 || rdAddr >= 4'd13)) |=> (rdData == 16'h0000));
  assert_idle_before_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !seenEnable) |=> (rdData == 16'h0000));
  assert_full_falls_on_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statsFull) |-> $past(rdEn));
endmodule

bind stats_counter_bank stats_counter_bank_checker i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .statsEnable (statsEnable),
  .rdEn        (rdEn),
  .rdAddr      (rdAddr),
  .rdData      (rdData),
  .rdValid     (rdValid),
  .statsFull   (statsFull)
);

// File: tb/test_stats_counter_bank.sv
module test_stats_counter_bank;
  logic        clk = 1'b0;
  logic        rstN;
  logic        statsEnable;
  logic [8:0]  evtPulse;
  logic [2:0]  rxByteInc;
  logic [2:0]  txByteInc;
  logic        rdEn;
  logic [3:0]  rdAddr;
  logic [15:0] rdData;
  logic        rdValid;
  logic        statsFull;

  always #5 clk = ~clk;

  stats_counter_bank i_stats_counter_bank (
    .clk(clk), .rstN(rstN), .statsEnable(statsEnable), .evtPulse(evtPulse),
    .rxByteInc(rxByteInc), .txByteInc(txByteInc), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .rdValid(rdValid), .statsFull(statsFull)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model
  logic [7:0]  mByte [9];
  logic [1:0]  mExt;
  logic [15:0] mRx, mTx;
  bit          mEn;

  logic [15:0] expQ [$];
  string       tagQ [$];

  function automatic logic [15:0] modelRead(input logic [3:0] a);
    if (a <= 4'd8) return {8'h00, mByte[a]};
    if (a == 4'd9) return {10'h0, mExt, 4'h0};
    if (a == 4'd10) return mRx;
    if (a == 4'd12) return mTx;
    return 16'h0000;
  endfunction

  function automatic bit modelFull();
    bit f = 0;
    for (int i = 0; i < 9; i++) if (i != 6 && mByte[i][7]) f = 1;
    return f | mExt[1] | mRx[15] | mTx[15];
  endfunction

  task automatic step(input logic [8:0] ev, input logic [2:0] rxi, input logic [2:0] txi,
                      input bit rd, input logic [3:0] a, input string tag, input bit en = 0);
    logic [8:0] sum6;
    @(negedge clk);
    evtPulse = ev; rxByteInc = rxi; txByteInc = txi;
    rdEn = rd; rdAddr = a; statsEnable = en;
    if (rd) begin
      expQ.push_back(modelRead(a));
      tagQ.push_back(tag);
      if (a <= 4'd8) mByte[a] = 8'h00;
      else if (a == 4'd9) mExt = 2'b00;
      else if (a == 4'd10) mRx = 16'h0;
      else if (a == 4'd12) mTx = 16'h0;
    end
    if (mEn) begin
      for (int i = 0; i < 9; i++) begin
        if (i == 6) begin
          sum6 = {1'b0, mByte[6]} + 9'(ev[6]);
          mByte[6] = sum6[7:0];
          mExt = mExt + 2'(sum6[8]);
        end else begin
          mByte[i] = mByte[i] + 8'(ev[i]);
        end
      end
      mRx = mRx + 16'(rxi);
      mTx = mTx + 16'(txi);
    end
    if (en) mEn = 1;
    @(posedge clk);
    #1;
    evtPulse = '0; rxByteInc = '0; txByteInc = '0; rdEn = 0; statsEnable = 0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step('0, '0, '0, 1, a, tag);
  endtask

  task automatic checkFull(input string tag);
    checks++;
    if (statsFull !== modelFull()) begin
      errors++;
      $display("FAIL %s statsFull actual %0b expected %0b", tag, statsFull, modelFull());
    end
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rstN && rdValid && !finished) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected rdValid actual %h expected none", rdData);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdData !== e) begin
          errors++;
          $display("FAIL %s rdData actual %h expected %h", t, rdData, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 9; i++) mByte[i] = 8'h00;
    mExt = 0; mRx = 0; mTx = 0; mEn = 0;
    rstN = 0; statsEnable = 0; evtPulse = 0; rxByteInc = 0; txByteInc = 0;
    rdEn = 0; rdAddr = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1: reset state
    checks++;
    if (statsFull !== 1'b0 || rdValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 statsFull/rdValid actual %b%b expected 00", statsFull, rdValid);
    end
    for (int a = 0; a < 16; a++) rd(4'(a), "R1 reset value");

    // R2: events ignored before enable
    for (int k = 0; k < 5; k++) step(9'h1FF, 3'd7, 3'd7, 0, 0, "");
    for (int a = 0; a <= 12; a++) rd(4'(a), "R2 no count before enable");
    step(9'h1FF, 3'd5, 3'd5, 0, 0, "", 1); // enable cycle itself not counted
    for (int a = 0; a <= 12; a++) rd(4'(a), "R2 enable cycle not counted");

    // R3 R9: counter i gets i+1 pulses, byte counters get varied increments
    for (int k = 0; k < 9; k++) begin
      logic [8:0] m;
      for (int i = 0; i < 9; i++) m[i] = (k <= i);
      step(m, 3'(k), 3'(7 - k % 8), 0, 0, "");
    end
    checkFull("R10 below top bit");
    // R5: read one counter, others unaffected
    rd(4'd3, "R3 single collisions count");
    rd(4'd3, "R5 cleared after read");
    for (int a = 0; a <= 12; a++) rd(4'(a), "R3 R9 per-offset count");

    // R6: event in the read cycle survives
    step(9'h001, 0, 0, 0, 0, "");
    step(9'h001, 3'd4, 0, 1, 4'd0, "R6 read with concurrent event");
    rd(4'd0, "R6 restart at one");
    step(0, 3'd4, 0, 0, 0, "");
    step(0, 3'd3, 0, 1, 4'd10, "R6 byte read with concurrent inc");
    rd(4'd10, "R6 byte restart at inc");

    // R7 R8: 260 transmitted frames -> low 4, ext 1
    for (int k = 0; k < 260; k++) step(9'h040, 0, 0, 0, 0, "");
    rd(4'd9, "R7 extension bits");
    rd(4'd6, "R8 low byte kept after ext read");
    for (int k = 0; k < 300; k++) step(9'h040, 0, 0, 0, 0, "");
    rd(4'd6, "R8 low byte read");
    rd(4'd9, "R8 ext kept after low read");
    rd(4'd9, "R8 ext cleared");

    // R10: tx frame low byte top bit does not raise full
    for (int k = 0; k < 200; k++) step(9'h040, 0, 0, 0, 0, "");
    checkFull("R10 tx frame low byte bit 7");
    rd(4'd6, "R10 low byte");
    for (int k = 0; k < 512; k++) step(9'h040, 0, 0, 0, 0, "");
    checkFull("R10 tx frame bit 9");
    rd(4'd9, "R10 ext read");
    checkFull("R10 cleared by ext read");
    rd(4'd6, "R10 low after");
    for (int k = 0; k < 128; k++) step(9'h010, 0, 0, 0, 0, "");
    checkFull("R10 late collisions at 128");
    rd(4'd4, "R10 late collisions value");
    checkFull("R10 falls after read");
    for (int k = 0; k < 4700; k++) step(0, 3'd7, 0, 0, 0, "");
    checkFull("R10 rx bytes top bit");
    rd(4'd10, "R9 rx bytes value");
    checkFull("R10 falls after rx bytes read");

    // R11: unmapped offsets read zero and clear nothing
    for (int k = 0; k < 3; k++) step(9'h1FF, 3'd2, 3'd1, 0, 0, "");
    rd(4'd11, "R11 offset 11"); rd(4'd13, "R11 offset 13");
    rd(4'd14, "R11 offset 14"); rd(4'd15, "R11 offset 15");
    for (int a = 0; a <= 12; a++) rd(4'(a), "R11 nothing cleared");

    // mixed traffic with rotating reads
    for (int k = 0; k < 3000; k++) begin
      logic [8:0] m;
      m = 9'($urandom) & 9'($urandom);
      step(m, 3'($urandom), 3'($urandom), (k % 2) == 0, 4'((k / 2) % 14),
           "R5 R6 mixed traffic");
      if (k % 50 == 0) checkFull("R10 mixed traffic");
    end

    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R4 missing results actual %0d pending expected 0", expQ.size());
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule